// File: doc/BRIEF.md
# Burst-Mode Memory Read Front-End

This block sits in front of a small word-wide read-only array and serves reads in one of two ways. In asynchronous mode a word is presented once chip select and the address have been steady for a set number of clocks and output enable has been high for a second, separate number of clocks. In burst mode an address strobe latches a start address. A programmable latency then runs, after which the block delivers one word per clock at rising addresses. A ready output marks the clocks that carry valid data.

A 16-bit configuration register picks the mode, the initial latency, the burst ordering and when ready asserts. The ordering is either endless increment, with a one-clock pause when the address wraps from the top of the array to 0, or an 8-word wrap inside an aligned group. The register comes up in asynchronous mode. It takes writes only while no burst runs. Dropping chip select stops a burst at once, and a new strobe starts a fresh latency count.

The array holds computed content: the word at address a is (a * 257) mod 65536 XOR 16'hC3A5.

Top module: `burst_rd_frontend`

## Requirements
- R1: After reset the configuration register reads 16'h8000, so bit 15 = 1 selects asynchronous mode. rdy and rdata are 0 while chip_sel and out_en are low. In asynchronous mode an address strobe starts no burst: with out_en low, rdy stays 0.
- R2: In asynchronous mode, rdy = 1 and rdata = the array word at addr once two conditions hold. First, out_en must have been high at the last OE_DLY rising edges (default 2). Second, chip_sel must have been high with the address unchanged from the previous edge at the last CE_DLY rising edges (default 3).
- R3: Configuration bits 13:11 hold a wait field n. The initial latency is L = n+2 clocks, and every n of 5 or more gives 7. When the strobe is sampled at edge E0 in burst mode (bit 15 = 0), the first word is presented after edge E_L. rdy is 0 after E0 through E_(L-1).
- R4: After the first word, each clock presents the next word at a rising address, with rdy = 1. rdata is 0 in every clock whose word is not valid.
- R5: Configuration bits 2:0 = 3'b010 select an 8-word wrap: the address bits above bit 2 stay fixed and the low three bits count modulo 8. Every other value selects continuous order.
- R6: In continuous order, the word at the top address (DEPTH-1) is followed by one clock with rdy = 0 and rdata = 0, and then by address 0.
- R7: Configuration bit 10 = 1 makes rdy lead the data by one clock: rdy in a clock equals the data-valid status of the following clock. Bit 10 = 0 makes rdy coincide with valid data.
- R8: With chip_sel low, rdy and rdata are 0 in the same clock. The burst ends, and it does not resume when chip_sel returns without a new strobe.
- R9: A strobe during a running burst, with chip_sel high, restarts the latency count from the new address.
- R10: A configuration write (cfg_we) takes effect at the clock edge only while no burst is active, and is ignored otherwise. cfg_rdata always returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel | input | 1 | Chip select, active high |
| out_en | input | 1 | Output enable, active high |
| addr_strobe | input | 1 | Latches addr and starts a burst in burst mode |
| addr | input | AW | Word address (AW = log2 DEPTH) |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Stored configuration value |
| rdata | output | 16 | Read data, 0 when not valid |
| rdy | output | 1 | Data-ready indication |

## Verification
Two functions can land in the same clock: the one-clock pause at the top-of-array wrap, and the one-clock-early ready lookahead. Both fall in the clock before the pause, and also in the pause clock itself. The bench provokes this by starting an early-ready continuous burst two words below the top address. It judges the result by deriving the expected early ready from its own model of the plain-ready sequence, shifted by one clock. That gives ready low on the last word before the pause and high during the pause.

// File: rtl/brf_pkg.sv
package brf_pkg;

    localparam int CFG_W        = 16;
    localparam int DATA_W       = 16;
    localparam int MODE_BIT     = 15;
    localparam int EARLY_BIT    = 10;
    localparam int WS_HI        = 13;
    localparam int WS_LO        = 11;
    localparam int LEN_HI       = 2;
    localparam int LEN_LO       = 0;
    localparam int GROUP_BITS   = 3;

    localparam logic [CFG_W-1:0] CFG_RESET = 16'h8000;
    localparam logic [2:0]       LEN_WRAP8 = 3'b010;

    typedef enum logic [1:0] {
        BS_IDLE,
        BS_WAIT,
        BS_DATA,
        BS_GAP
    } burst_st_e;

    typedef struct packed {
        logic       sync_mode;
        logic       rdy_early;
        logic       wrap8;
        logic [2:0] latency;
    } cfg_dec_t;

    function automatic logic [2:0] ws_to_latency(input logic [2:0] ws);
        return (ws > 3'd5) ? 3'd7 : ws + 3'd2;
    endfunction

    function automatic logic [DATA_W-1:0] array_word(input int unsigned a);
        logic [31:0] p;
        p = a * 32'd257;
        return p[DATA_W-1:0] ^ 16'hC3A5;
    endfunction

endpackage

// File: rtl/brf_array.sv
module brf_array
    import brf_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic [AW-1:0]     addr_a,
    input  logic [AW-1:0]     addr_b,
    output logic [DATA_W-1:0] word_a,
    output logic [DATA_W-1:0] word_b
);

    logic [DATA_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = array_word(g);
    end

    assign word_a = rom[addr_a];
    assign word_b = rom[addr_b];

endmodule

// File: rtl/brf_cfg.sv
module brf_cfg
    import brf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             lock,
    output logic [CFG_W-1:0] cfg_q,
    output cfg_dec_t         dec
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (we && !lock) begin
            cfg_q <= wdata;
        end
    end

    always_comb begin
        dec.sync_mode = !cfg_q[MODE_BIT];
        dec.rdy_early = cfg_q[EARLY_BIT];
        dec.wrap8     = (cfg_q[LEN_HI:LEN_LO] == LEN_WRAP8);
        dec.latency   = ws_to_latency(cfg_q[WS_HI:WS_LO]);
    end

endmodule

// File: rtl/brf_burst.sv
module brf_burst
    import brf_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chip_sel,
    input  logic          strobe,
    input  logic [AW-1:0] addr,
    input  cfg_dec_t      dec,
    output logic          valid,
    output logic          valid_nxt,
    output logic          active,
    output logic [AW-1:0] cur_addr
);

    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    burst_st_e     st, st_n;
    logic [AW-1:0] addr_n;
    logic [2:0]    cnt, cnt_n;
    logic [AW-1:0] incr_addr;
    logic [AW-1:0] wrap_addr;

    assign incr_addr = cur_addr + AW'(1);

    if (AW > GROUP_BITS) begin : g_wrap_wide
        assign wrap_addr = {cur_addr[AW-1:GROUP_BITS],
                            cur_addr[GROUP_BITS-1:0] + GROUP_BITS'(1)};
    end else begin : g_wrap_narrow
        assign wrap_addr = incr_addr;
    end

    always_comb begin
        st_n   = st;
        addr_n = cur_addr;
        cnt_n  = cnt;
        if (!chip_sel) begin
            st_n = BS_IDLE;
        end else if (strobe && dec.sync_mode) begin
            st_n   = BS_WAIT;
            addr_n = addr;
            cnt_n  = dec.latency;
        end else begin
            unique case (st)
                BS_WAIT: begin
                    if (cnt == 3'd1) st_n = BS_DATA;
                    else             cnt_n = cnt - 3'd1;
                end
                BS_DATA: begin
                    if (dec.wrap8) begin
                        addr_n = wrap_addr;
                    end else if (cur_addr == TOP) begin
                        st_n   = BS_GAP;
                        addr_n = '0;
                    end else begin
                        addr_n = incr_addr;
                    end
                end
                BS_GAP:  st_n = BS_DATA;
                default: st_n = BS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= BS_IDLE;
            cur_addr <= '0;
            cnt      <= '0;
        end else begin
            st       <= st_n;
            cur_addr <= addr_n;
            cnt      <= cnt_n;
        end
    end

    assign valid     = (st == BS_DATA);
    assign valid_nxt = (st_n == BS_DATA);
    assign active    = (st != BS_IDLE);

endmodule

// File: rtl/brf_async.sv
module brf_async #(
    parameter  int DEPTH  = 64,
    parameter  int CE_DLY = 3,
    parameter  int OE_DLY = 2,
    localparam int AW     = $clog2(DEPTH),
    localparam int MAXD   = (CE_DLY > OE_DLY) ? CE_DLY : OE_DLY,
    localparam int CW     = $clog2(MAXD + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chip_sel,
    input  logic          out_en,
    input  logic [AW-1:0] addr,
    output logic          ready
);

    logic [AW-1:0] last_addr;
    logic [CW-1:0] ce_cnt;
    logic [CW-1:0] oe_cnt;

    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
        return (v == CW'(MAXD)) ? v : v + CW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            last_addr <= '0;
            ce_cnt    <= '0;
            oe_cnt    <= '0;
        end else begin
            last_addr <= addr;
            ce_cnt    <= (chip_sel && addr == last_addr) ? sat_inc(ce_cnt) : '0;
            oe_cnt    <= out_en ? sat_inc(oe_cnt) : '0;
        end
    end

    assign ready = (ce_cnt >= CW'(CE_DLY)) && (oe_cnt >= CW'(OE_DLY));

endmodule

// File: rtl/burst_rd_frontend.sv
module burst_rd_frontend
    import brf_pkg::*;
#(
    parameter  int DEPTH  = 64,
    parameter  int CE_DLY = 3,
    parameter  int OE_DLY = 2,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_sel,
    input  logic              out_en,
    input  logic              addr_strobe,
    input  logic [AW-1:0]     addr,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdy
);

    cfg_dec_t          dec;
    logic              burst_valid;
    logic              burst_valid_nxt;
    logic              burst_active;
    logic [AW-1:0]     cur_addr;
    logic              async_ready;
    logic [DATA_W-1:0] word_async;
    logic [DATA_W-1:0] word_burst;
    logic              sync_mode;
    logic              wrap8;
    logic              rdy_early;
    logic              word_ok;

    assign sync_mode = dec.sync_mode;
    assign wrap8     = dec.wrap8;
    assign rdy_early = dec.rdy_early;

    brf_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .lock  (burst_active),
        .cfg_q (cfg_rdata),
        .dec   (dec)
    );

    brf_burst #(.DEPTH(DEPTH)) u_burst (
        .clk       (clk),
        .rst       (rst),
        .chip_sel  (chip_sel),
        .strobe    (addr_strobe),
        .addr      (addr),
        .dec       (dec),
        .valid     (burst_valid),
        .valid_nxt (burst_valid_nxt),
        .active    (burst_active),
        .cur_addr  (cur_addr)
    );

    brf_async #(.DEPTH(DEPTH), .CE_DLY(CE_DLY), .OE_DLY(OE_DLY)) u_async (
        .clk      (clk),
        .rst      (rst),
        .chip_sel (chip_sel),
        .out_en   (out_en),
        .addr     (addr),
        .ready    (async_ready)
    );

    brf_array #(.DEPTH(DEPTH)) u_array (
        .addr_a (addr),
        .addr_b (cur_addr),
        .word_a (word_async),
        .word_b (word_burst)
    );

    always_comb begin
        if (sync_mode) begin
            word_ok = burst_valid;
            rdy     = chip_sel && (rdy_early ? burst_valid_nxt : burst_valid);
        end else begin
            word_ok = async_ready;
            rdy     = chip_sel && out_en && async_ready;
        end
        rdata = (chip_sel && out_en && word_ok)
              ? (sync_mode ? word_burst : word_async) : '0;
    end

endmodule

// File: rtl/brf_checker.sv
module brf_checker
    import brf_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             chip_sel,
    input logic             addr_strobe,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             rdy,
    input logic             burst_valid,
    input logic             burst_active,
    input logic [AW-1:0]    cur_addr,
    input logic             sync_mode,
    input logic             wrap8
);

    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    // R1: register holds its reset value on the first cycle after reset
    p_reset_cfg_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cfg_rdata == CFG_RESET);

    // R3: no ready in the clock after a burst strobe
    p_first_wait_r3: assert property (@(posedge clk) disable iff (rst)
        (addr_strobe && chip_sel && sync_mode && !cfg_we) |=> !rdy);

    // R4: one word per clock at a rising address
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (burst_valid && chip_sel && !addr_strobe && !wrap8 && cur_addr != TOP)
        |=> (burst_valid && cur_addr == AW'($past(cur_addr) + 1)));

    // R5: 8-word wrap keeps the group address
    p_wrap_group_r5: assert property (@(posedge clk) disable iff (rst)
        (burst_valid && chip_sel && !addr_strobe && wrap8)
        |=> (cur_addr[AW-1:GROUP_BITS] == $past(cur_addr[AW-1:GROUP_BITS])));

    // R6: top of array is followed by a pause and address 0
    p_top_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (burst_valid && chip_sel && !addr_strobe && !wrap8 && cur_addr == TOP)
        |=> (!burst_valid && cur_addr == '0));

    // R8: no ready without chip select
    p_cs_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !chip_sel |-> !rdy);

    // R9: a strobe cancels the word stream of a running burst
    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (addr_strobe && chip_sel && sync_mode) |=> !burst_valid);

    // R10: writes during a burst leave the register unchanged
    p_cfg_locked_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && burst_active) |=> $stable(cfg_rdata));

endmodule

bind burst_rd_frontend brf_checker #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .chip_sel     (chip_sel),
    .addr_strobe  (addr_strobe),
    .cfg_we       (cfg_we),
    .cfg_rdata    (cfg_rdata),
    .rdy          (rdy),
    .burst_valid  (burst_valid),
    .burst_active (burst_active),
    .cur_addr     (cur_addr),
    .sync_mode    (sync_mode),
    .wrap8        (wrap8)
);

// File: tb/tb_burst_rd_frontend.sv
module tb_burst_rd_frontend;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int AW         = $clog2(DEPTH);

    typedef struct {
        logic        rdy;
        logic [15:0] data;
        string       req;
    } exp_item_t;

    logic          clk = 1'b0;
    logic          rst;
    logic          chip_sel;
    logic          out_en;
    logic          addr_strobe;
    logic [AW-1:0] addr;
    logic          cfg_we;
    logic [15:0]   cfg_wdata;
    logic [15:0]   cfg_rdata;
    logic [15:0]   rdata;
    logic          rdy;

    int n_chk  = 0;
    int n_fail = 0;
    exp_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_rd_frontend #(.DEPTH(DEPTH)) dut (
        .clk         (clk),
        .rst         (rst),
        .chip_sel    (chip_sel),
        .out_en      (out_en),
        .addr_strobe (addr_strobe),
        .addr        (addr),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .rdata       (rdata),
        .rdy         (rdy)
    );

    function automatic logic [15:0] model_word(input int a);
        int p;
        p = (a * 257) % 65536;
        return 16'(p) ^ 16'hC3A5;
    endfunction

    function automatic logic [15:0] mk_cfg(input int ws, input bit early, input logic [2:0] len);
        return {1'b0, 1'b0, 3'(ws), early, 7'b0, len};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // monitor: pops one expected item per clock while the queue is not empty
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_item_t it;
            it = sb_q.pop_front();
            check({it.req, " rdy"},   32'(rdy),   32'(it.rdy));
            check({it.req, " rdata"}, 32'(rdata), 32'(it.data));
        end
    end

    task automatic write_cfg(input logic [15:0] v);
        @(posedge clk); #2;
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(posedge clk); #2;
        cfg_we    = 1'b0;
    endtask

    task automatic idle_and_write(input logic [15:0] v);
        @(posedge clk); #2;
        chip_sel = 1'b0;
        write_cfg(v);
        check("R10 readback", 32'(cfg_rdata), 32'(v));
        chip_sel = 1'b1;
    endtask

    // driver: strobes a burst and pushes the expected per-clock outputs
    task automatic run_burst(input int start, input int ws, input bit wrap,
                             input bit early, input int nwords, input string req);
        logic r[$];
        logic [15:0] d[$];
        int lat, a, nd;
        lat = (ws > 5) ? 7 : ws + 2;
        for (int i = 0; i < lat; i++) begin
            r.push_back(1'b0);
            d.push_back(16'h0);
        end
        a  = start;
        nd = 0;
        while (nd <= nwords) begin
            r.push_back(1'b1);
            d.push_back(model_word(a));
            nd++;
            if (!wrap && a == DEPTH - 1) begin
                r.push_back(1'b0);
                d.push_back(16'h0);
                a = 0;
            end else if (wrap) begin
                a = (a & ~7) | ((a + 1) & 7);
            end else begin
                a = a + 1;
            end
        end
        @(posedge clk); #2;
        addr        = AW'(start);
        addr_strobe = 1'b1;
        @(posedge clk); #2;
        addr_strobe = 1'b0;
        for (int i = 0; i < r.size() - 1; i++) begin
            exp_item_t it;
            it.rdy  = early ? r[i+1] : r[i];
            it.data = d[i];
            it.req  = req;
            sb_q.push_back(it);
        end
        while (sb_q.size() != 0) @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        rst = 1'b1; chip_sel = 1'b0; out_en = 1'b0; addr_strobe = 1'b0;
        addr = '0; cfg_we = 1'b0; cfg_wdata = '0;
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        check("R1 reset cfg", 32'(cfg_rdata), 32'h8000);
        check("R1 reset rdy", 32'(rdy), 32'h0);
        check("R1 reset rdata", 32'(rdata), 32'h0);

        // R1: strobe in asynchronous mode starts no burst
        @(posedge clk); #2;
        addr = AW'(5); chip_sel = 1'b1; addr_strobe = 1'b1;
        @(posedge clk); #2;
        addr_strobe = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R1 strobe ignored rdy", 32'(rdy), 32'h0);

        // R2: output enable delay
        @(posedge clk); #2;
        out_en = 1'b1;
        @(negedge clk);
        check("R2 oe 0 edges rdy", 32'(rdy), 32'h0);
        @(negedge clk);
        check("R2 oe 1 edge rdy", 32'(rdy), 32'h0);
        @(negedge clk);
        check("R2 oe 2 edges rdy", 32'(rdy), 32'h1);
        check("R2 oe 2 edges rdata", 32'(rdata), 32'(model_word(5)));

        // R2: address change restarts the chip-select delay
        @(posedge clk); #2;
        addr = AW'(9);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2 addr 3 edges rdy", 32'(rdy), 32'h0);
        @(negedge clk);
        check("R2 addr 4 edges rdy", 32'(rdy), 32'h1);
        check("R2 addr 4 edges rdata", 32'(rdata), 32'(model_word(9)));

        // R3 R4: minimum latency, continuous
        idle_and_write(mk_cfg(0, 1'b0, 3'b000));
        run_burst(3, 0, 1'b0, 1'b0, 6, "R3 R4 ws0");

        // R9: restart during a running burst
        run_burst(20, 0, 1'b0, 1'b0, 2, "R9 first");
        run_burst(40, 0, 1'b0, 1'b0, 4, "R9 restart");

        // R5: 8-word wrap, ws3
        idle_and_write(mk_cfg(3, 1'b0, 3'b010));
        run_burst(13, 3, 1'b1, 1'b0, 10, "R5 wrap8");

        // R6 R3: clamp at ws7, length 001 acts as continuous
        idle_and_write(mk_cfg(7, 1'b0, 3'b001));
        run_burst(61, 7, 1'b0, 1'b0, 5, "R6 R5 ws7 top wrap");

        // R7 with R6: early ready across the top wrap
        idle_and_write(mk_cfg(1, 1'b1, 3'b000));
        run_burst(62, 1, 1'b0, 1'b1, 4, "R7 early gap");

        // R3: ws5 gives 7 clocks
        idle_and_write(mk_cfg(5, 1'b0, 3'b000));
        run_burst(0, 5, 1'b0, 1'b0, 3, "R3 ws5");

        // R10: write during a burst is ignored
        write_cfg(16'h8000);
        check("R10 locked write", 32'(cfg_rdata), 32'(mk_cfg(5, 1'b0, 3'b000)));

        // R8: chip select drop ends the burst at once
        @(posedge clk); #2;
        chip_sel = 1'b0;
        #1;
        check("R8 drop rdy", 32'(rdy), 32'h0);
        check("R8 drop rdata", 32'(rdata), 32'h0);
        @(posedge clk); #2;
        chip_sel = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check("R8 no resume rdy", 32'(rdy), 32'h0);
        end

        // R10: idle write accepted
        idle_and_write(16'h8000);

        report();
        $finish;
    end

endmodule